// File: doc/BRIEF.md
# Compact Instruction Expander

This block turns one 16-bit compact instruction into the equivalent 32-bit base-ISA instruction word, so that the existing 32-bit decoder can execute compact code without a second decode path. It is purely combinational. Each fetch returns a 32-bit word that holds two compact instructions. An endianness input chooses which of the two is current, and a feature-level input allows the newer register-exchange call form.

The 5-bit major opcode in bits [15:11] of the current halfword picks a format. The block then ORs the relocated operand fields into a fixed base word, which depends on the format and its sub-opcode. A 2-bit status goes with the result: 00 means expanded, 01 means undefined, and 10 means branch-class. Branch-class instructions are resolved by other logic, and their target arithmetic is not done here. When the status is not 00, the word output carries the marker 0xDEADC0DE.

Top module: `cx_expander`

## Requirements
- R1: When `big_endian` is 1, the current halfword is `fetch_word[31:16]`. Otherwise it is `fetch_word[15:0]`. The other halfword has no effect on the outputs.
- R2: Majors 0 to 2 expand to 0xE1B00000, with bits [12:11] placed at [6:5], [10:6] at [11:7], [5:3] at [3:0] and [2:0] at [15:12].
- R3: Major 3 takes its base from bits [10:9]: 0 gives 0xE0900000, 1 gives 0xE0500000, 2 gives 0xE2900000 and 3 gives 0xE2500000. Bits [8:6] go to [3:0], [5:3] to [19:16] and [2:0] to [15:12].
- R4: Majors 4 to 7 take their base from bits [12:11]: 0 gives 0xE3B00000, 1 gives 0xE3500000, 2 gives 0xE2900000 and 3 gives 0xE2500000. imm8 goes to [7:0], and [10:8] is copied to both [19:16] and [15:12].
- R5: Major 8 with bit 10 clear uses bits [9:6] to pick one of 16 base words. The plain entries place Rd=[2:0] at [19:16] and [15:12] and Rs=[5:3] at [3:0]. The shift entries (2, 3, 4, 7) place Rd at [15:12] and [3:0] and Rs at [11:8]. The negate entry (9, 0xE2700000) places Rd at [15:12] and Rs at [19:16]. The multiply entry (13, 0xE0100090) places Rd at [19:16] and [11:8] and Rs at [3:0].
- R6: Major 8 with bit 10 set forms 4-bit registers. Bit 7 extends the destination and bit 6 extends the source. Sub-opcodes 1 to 3 give add (0xE0800000), 5 to 7 give compare (0xE1500000) and 9 to 11 give move (0xE1A00000). Each of these places the destination at [19:16] and [15:12] and the source at [3:0]. Sub-opcodes 12 and 13 give 0xE12FFF10 with bits [6:3] placed at [3:0]. Sub-opcodes 0, 4 and 8 are undefined.
- R7: Sub-opcodes 14 and 15 of the high-register group expand to 0xE1200030 with the source register at [3:0] only when `xchg_call_en` is 1. Otherwise they are undefined.
- R8: Major 9 gives 0xE59F0000 with [10:8] at [15:12] and imm8 shifted left by 2. Majors 10 and 11 use bit 9 to pick between the word/byte table {0xE7800000, 0xE7C00000, 0xE7900000, 0xE7D00000} and the halfword/signed table {0xE18000B0, 0xE19000D0, 0xE19000B0, 0xE19000F0}, indexed by [11:10]. Bits [2:0] go to [15:12], [5:3] to [19:16] and [8:6] to [3:0].
- R9: Majors 12 to 15 take their base from [12:11]: {0xE5800000, 0xE5900000, 0xE5C00000, 0xE5D00000}. The offset [10:6] is shifted left by 2 when bit 12 is 0 and left unshifted when bit 12 is 1. Majors 16 and 17 give 0xE1D000B0 when bit 11 is set and 0xE1C000B0 otherwise, with offset bits [8:6] at [3:1] and [10:9] at [9:8]. Majors 18 and 19 give 0xE59D0000 when bit 11 is set and 0xE58D0000 otherwise, with [10:8] at [15:12] and imm8 shifted left by 2.
- R10: Majors 20 and 21 give 0xE28D0F00 when bit 11 is set and 0xE28F0F00 otherwise, with [10:8] at [15:12] and imm8 unshifted at [7:0]. Majors 22 and 23 with [11:8]=0000 give 0xE24DDF00 when bit 7 is set and 0xE28DDF00 otherwise, with imm7 at [6:0].
- R11: Majors 22 and 23 with [11:8] other than 0000 and 1110 take their base from {bit 11, bit 8}: {0xE92D0000, 0xE92D4000, 0xE8BD0000, 0xE8BD8000}, ORed with the mask [7:0]. Majors 24 and 25 give 0xE8B00000 when bit 11 is set and 0xE8A00000 otherwise, with [10:8] at [19:16] and the mask at [7:0].
- R12: Majors 22 and 23 with [11:8]=1110 are undefined. Majors 26 and 27 are undefined when [11:8]=1110 and branch-class otherwise. Major 29 is undefined when bit 0 is 1. Majors 28, 29 (bit 0 clear), 30 and 31 are branch-class.
- R13: Status 00 means expanded, 01 undefined and 10 branch-class. When the status is not 00, `exp_word` is 0xDEADC0DE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fetch_word | input | 32 | Fetch word holding two compact instructions |
| big_endian | input | 1 | 1 selects the upper halfword as current |
| xchg_call_en | input | 1 | Enables the register-exchange call form |
| exp_word | output | 32 | Expanded 32-bit instruction, or the marker |
| exp_status | output | 2 | 00 expanded, 01 undefined, 10 branch-class |

## Verification
The assertions are checked on every input change. They cover the shift-format base and destination, undefined high-register sub-opcodes, gating of the exchange call by the feature input, the multiple-transfer mask, and the branch-class classification of the upper majors. Exact field relocation for every format, the offset scaling, the half selection and the marker on the word output are shown only by the bench. The bench compares every one of the 65536 halfword values against its own expansion model, in both endianness settings and with the feature input both on and off.

// File: rtl/cx_pkg.sv
// Shared constants, status codes and helpers for the compact expander.
// Assumes a 16-bit compact instruction and a 32-bit expanded word.
package cx_pkg;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned WORD_W = 32;
    localparam logic [WORD_W-1:0] CX_MARKER = 32'hDEADC0DE;

    typedef enum logic [1:0] {
        CX_EXPANDED = 2'b00,
        CX_UNDEF    = 2'b01,
        CX_BRANCH   = 2'b10
    } cx_status_e;

    typedef struct packed {
        logic              undef;
        logic [WORD_W-1:0] word;
    } cx_xlate_t;

    // Place a 4-bit register number at a bit position of the expanded word.
    function automatic logic [WORD_W-1:0] place(input logic [3:0] v, input int unsigned pos);
        return WORD_W'(v) << pos;
    endfunction
endpackage

// File: rtl/cx_half_pick.sv
// Chooses the current compact instruction out of a two-instruction fetch word.
// Assumes the fetch word is exactly two halfwords wide.
module cx_half_pick #(
    parameter int unsigned HALF_W = 16,
    localparam int unsigned FETCH_W = 2 * HALF_W
) (
    input  logic [FETCH_W-1:0] fetch_word,
    input  logic               big_endian,
    output logic [HALF_W-1:0]  half
);
    // Upper halfword is current for big-endian, lower otherwise.
    always_comb begin
        half = big_endian ? fetch_word[FETCH_W-1:HALF_W] : fetch_word[HALF_W-1:0];
    end
endmodule

// File: rtl/cx_alu_xlate.sv
// Expands the data-processing majors 0..8 (shifts, add/sub, imm8, register ALU
// and high-register group). Assumes the caller only uses the result for majors 0..8.
module cx_alu_xlate
    import cx_pkg::*;
(
    input  logic [HALF_W-1:0] half,
    input  logic              xchg_en,
    output cx_xlate_t         res
);
    typedef enum logic [1:0] {K_PLAIN, K_SHIFT, K_NEG, K_MUL} alu_kind_e;

    logic [3:0]        rd, rs, rh, hd, hs;
    logic [WORD_W-1:0] alu_base;
    alu_kind_e         alu_kind;

    // Register ALU table: base word and operand layout per sub-opcode.
    always_comb begin
        alu_kind = K_PLAIN;
        case (half[9:6])
            4'd0:  alu_base = 32'hE0100000;
            4'd1:  alu_base = 32'hE0300000;
            4'd2:  begin alu_base = 32'hE1B00010; alu_kind = K_SHIFT; end
            4'd3:  begin alu_base = 32'hE1B00030; alu_kind = K_SHIFT; end
            4'd4:  begin alu_base = 32'hE1B00050; alu_kind = K_SHIFT; end
            4'd5:  alu_base = 32'hE0B00000;
            4'd6:  alu_base = 32'hE0D00000;
            4'd7:  begin alu_base = 32'hE1B00070; alu_kind = K_SHIFT; end
            4'd8:  alu_base = 32'hE1100000;
            4'd9:  begin alu_base = 32'hE2700000; alu_kind = K_NEG; end
            4'd10: alu_base = 32'hE1500000;
            4'd11: alu_base = 32'hE1700000;
            4'd12: alu_base = 32'hE1900000;
            4'd13: begin alu_base = 32'hE0100090; alu_kind = K_MUL; end
            4'd14: alu_base = 32'hE1D00000;
            default: alu_base = 32'hE1F00000;
        endcase
    end

    // Operand fields, including high-register extensions.
    always_comb begin
        rd = {1'b0, half[2:0]};
        rs = {1'b0, half[5:3]};
        rh = {1'b0, half[10:8]};
        hd = {half[7], half[2:0]};
        hs = {half[6], half[5:3]};
    end

    // Per-major expansion.
    always_comb begin
        res.undef = 1'b0;
        res.word  = CX_MARKER;
        case (half[15:11])
            5'd0, 5'd1, 5'd2:
                res.word = 32'hE1B00000 | (WORD_W'(half[12:11]) << 5)
                         | (WORD_W'(half[10:6]) << 7) | place(rs, 0) | place(rd, 12);
            5'd3: begin
                case (half[10:9])
                    2'd0: res.word = 32'hE0900000;
                    2'd1: res.word = 32'hE0500000;
                    2'd2: res.word = 32'hE2900000;
                    default: res.word = 32'hE2500000;
                endcase
                res.word = res.word | place({1'b0, half[8:6]}, 0)
                         | place(rs, 16) | place(rd, 12);
            end
            5'd4, 5'd5, 5'd6, 5'd7: begin
                case (half[12:11])
                    2'd0: res.word = 32'hE3B00000;
                    2'd1: res.word = 32'hE3500000;
                    2'd2: res.word = 32'hE2900000;
                    default: res.word = 32'hE2500000;
                endcase
                res.word = res.word | WORD_W'(half[7:0]) | place(rh, 16) | place(rh, 12);
            end
            5'd8: begin
                if (!half[10]) begin
                    case (alu_kind)
                        K_SHIFT: res.word = alu_base | place(rd, 12) | place(rd, 0) | place(rs, 8);
                        K_NEG:   res.word = alu_base | place(rd, 12) | place(rs, 16);
                        K_MUL:   res.word = alu_base | place(rd, 16) | place(rd, 8) | place(rs, 0);
                        default: res.word = alu_base | place(rd, 16) | place(rd, 12) | place(rs, 0);
                    endcase
                end else begin
                    case (half[9:6])
                        4'd1, 4'd2, 4'd3:
                            res.word = 32'hE0800000 | place(hd, 16) | place(hd, 12) | place(hs, 0);
                        4'd5, 4'd6, 4'd7:
                            res.word = 32'hE1500000 | place(hd, 16) | place(hd, 12) | place(hs, 0);
                        4'd9, 4'd10, 4'd11:
                            res.word = 32'hE1A00000 | place(hd, 16) | place(hd, 12) | place(hs, 0);
                        4'd12, 4'd13:
                            res.word = 32'hE12FFF10 | place(half[6:3], 0);
                        4'd14, 4'd15: begin
                            if (xchg_en) res.word = 32'hE1200030 | place(hs, 0);
                            else         res.undef = 1'b1;
                        end
                        default: res.undef = 1'b1;
                    endcase
                end
            end
            default: res.undef = 1'b1;
        endcase
    end
endmodule

// File: rtl/cx_mem_xlate.sv
// Expands the memory and address majors 9..25 (literal load, register and
// immediate offsets, stack-relative, address generation, stack adjust,
// push/pop and multiple transfers). Assumes use only for majors 9..25.
module cx_mem_xlate
    import cx_pkg::*;
(
    input  logic [HALF_W-1:0] half,
    output cx_xlate_t         res
);
    logic [3:0] rd, rb, ro, rh;

    // Register fields shared by the memory formats.
    always_comb begin
        rd = {1'b0, half[2:0]};
        rb = {1'b0, half[5:3]};
        ro = {1'b0, half[8:6]};
        rh = {1'b0, half[10:8]};
    end

    // Per-major expansion.
    always_comb begin
        res.undef = 1'b0;
        res.word  = CX_MARKER;
        case (half[15:11])
            5'd9:
                res.word = 32'hE59F0000 | place(rh, 12) | (WORD_W'(half[7:0]) << 2);
            5'd10, 5'd11: begin
                case ({half[9], half[11:10]})
                    3'b000: res.word = 32'hE7800000;
                    3'b001: res.word = 32'hE7C00000;
                    3'b010: res.word = 32'hE7900000;
                    3'b011: res.word = 32'hE7D00000;
                    3'b100: res.word = 32'hE18000B0;
                    3'b101: res.word = 32'hE19000D0;
                    3'b110: res.word = 32'hE19000B0;
                    default: res.word = 32'hE19000F0;
                endcase
                res.word = res.word | place(rd, 12) | place(rb, 16) | place(ro, 0);
            end
            5'd12, 5'd13, 5'd14, 5'd15: begin
                case (half[12:11])
                    2'd0: res.word = 32'hE5800000;
                    2'd1: res.word = 32'hE5900000;
                    2'd2: res.word = 32'hE5C00000;
                    default: res.word = 32'hE5D00000;
                endcase
                res.word = res.word | place(rd, 12) | place(rb, 16)
                         | (half[12] ? WORD_W'(half[10:6]) : (WORD_W'(half[10:6]) << 2));
            end
            5'd16, 5'd17:
                res.word = (half[11] ? 32'hE1D000B0 : 32'hE1C000B0) | place(rd, 12)
                         | place(rb, 16) | (WORD_W'(half[8:6]) << 1) | (WORD_W'(half[10:9]) << 8);
            5'd18, 5'd19:
                res.word = (half[11] ? 32'hE59D0000 : 32'hE58D0000) | place(rh, 12)
                         | (WORD_W'(half[7:0]) << 2);
            5'd20, 5'd21:
                res.word = (half[11] ? 32'hE28D0F00 : 32'hE28F0F00) | place(rh, 12)
                         | WORD_W'(half[7:0]);
            5'd22, 5'd23: begin
                if (half[11:8] == 4'h0) begin
                    res.word = (half[7] ? 32'hE24DDF00 : 32'hE28DDF00) | WORD_W'(half[6:0]);
                end else if (half[11:8] == 4'hE) begin
                    res.undef = 1'b1;
                end else begin
                    case ({half[11], half[8]})
                        2'd0: res.word = 32'hE92D0000;
                        2'd1: res.word = 32'hE92D4000;
                        2'd2: res.word = 32'hE8BD0000;
                        default: res.word = 32'hE8BD8000;
                    endcase
                    res.word = res.word | WORD_W'(half[7:0]);
                end
            end
            5'd24, 5'd25:
                res.word = (half[11] ? 32'hE8B00000 : 32'hE8A00000) | place(rh, 16)
                         | WORD_W'(half[7:0]);
            default: res.undef = 1'b1;
        endcase
    end
endmodule

// File: rtl/cx_expander.sv
// Top of the compact instruction expander: picks the current halfword,
// routes it to the data-processing or memory translator, classifies the
// branch majors and forces the marker word for any non-expanded status.
// Assumes a purely combinational context; no clock or reset is used.
module cx_expander
    import cx_pkg::*;
#(
    parameter int unsigned HW = 16,
    localparam int unsigned FW = 2 * HW
) (
    input  logic [FW-1:0]  fetch_word,
    input  logic           big_endian,
    input  logic           xchg_call_en,
    output logic [31:0]    exp_word,
    output logic [1:0]     exp_status
);
    logic [HALF_W-1:0] half;
    logic [4:0]        major;
    cx_xlate_t         alu_res, mem_res, pick;
    cx_status_e        status;

    cx_half_pick #(.HALF_W(HW)) u_pick (
        .fetch_word (fetch_word),
        .big_endian (big_endian),
        .half       (half)
    );

    cx_alu_xlate u_alu (.half(half), .xchg_en(xchg_call_en), .res(alu_res));
    cx_mem_xlate u_mem (.half(half), .res(mem_res));

    // Major opcode used for routing.
    always_comb major = half[15:11];

    // Route to a translator or classify as branch / undefined.
    always_comb begin
        pick   = '{undef: 1'b1, word: CX_MARKER};
        status = CX_UNDEF;
        if (major <= 5'd8) begin
            pick   = alu_res;
            status = alu_res.undef ? CX_UNDEF : CX_EXPANDED;
        end else if (major <= 5'd25) begin
            pick   = mem_res;
            status = mem_res.undef ? CX_UNDEF : CX_EXPANDED;
        end else if (major <= 5'd27) begin
            status = (half[11:8] == 4'hE) ? CX_UNDEF : CX_BRANCH;
        end else if (major == 5'd29) begin
            status = half[0] ? CX_UNDEF : CX_BRANCH;
        end else begin
            status = CX_BRANCH;
        end
    end

    // Drive outputs, marker whenever nothing was expanded.
    always_comb begin
        exp_status = status;
        exp_word   = (status == CX_EXPANDED) ? pick.word : CX_MARKER;
    end

    // Immediate checks of output behaviour against the chosen halfword.
    always_comb begin
        if (major <= 5'd2) begin
            // R2
            shift_base_chk: assert (exp_status == 2'b00 && exp_word[31:20] == 12'hE1B
                                    && exp_word[15:12] == {1'b0, half[2:0]})
                else $error("shift format expansion wrong");
        end
        if (major == 5'd8 && half[10] && (half[9:6] == 4'd0 || half[9:6] == 4'd4 || half[9:6] == 4'd8)) begin
            // R6
            hi_undef_chk: assert (exp_status == 2'b01)
                else $error("undefined high-register sub-opcode not flagged");
        end
        if (major == 5'd8 && half[10] && half[9:7] == 3'b111 && !xchg_call_en) begin
            // R7
            xchg_gate_chk: assert (exp_status == 2'b01)
                else $error("exchange call expanded while disabled");
        end
        if (major == 5'd24 || major == 5'd25) begin
            // R11
            multi_mask_chk: assert (exp_status == 2'b00 && exp_word[7:0] == half[7:0])
                else $error("multiple transfer mask lost");
        end
        if (major >= 5'd28 && !(major == 5'd29 && half[0])) begin
            // R12
            branch_cls_chk: assert (exp_status == 2'b10)
                else $error("branch major not classified");
        end
    end
endmodule

// File: tb/cx_expander_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected expansions, the monitor pops
// and compares them half a clock later.
module cx_expander_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_word = '0;
    logic        big_endian = 1'b0;
    logic        xchg_call_en = 1'b0;
    logic [31:0] exp_word;
    logic [1:0]  exp_status;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    typedef struct {
        logic [15:0] h;
        logic [31:0] w;
        logic [1:0]  st;
        string       tag;
    } item_t;
    item_t sb[$];

    cx_expander u_dut (
        .fetch_word   (fetch_word),
        .big_endian   (big_endian),
        .xchg_call_en (xchg_call_en),
        .exp_word     (exp_word),
        .exp_status   (exp_status)
    );

    always #10 clk = ~clk;

    // Reference expansion written from the requirements.
    function automatic void ref_expand(input logic [15:0] h, input bit fl,
                                       output logic [31:0] w, output logic [1:0] st);
        logic [31:0] d, s, r8, hd, hs, ex;
        logic [4:0]  mj;
        logic [3:0]  op;
        mj = h[15:11]; op = h[9:6];
        d  = 32'(h[2:0]); s = 32'(h[5:3]); r8 = 32'(h[10:8]);
        hd = 32'({h[7], h[2:0]}); hs = 32'({h[6], h[5:3]});
        ex = 32'(h[8:6]);
        st = 2'b00; w = 32'h0;
        if (mj <= 2) w = 32'hE1B00000 + (32'(h[12:11]) << 5) + (32'(h[10:6]) << 7) + s + (d << 12);
        else if (mj == 3) begin
            case (h[10:9]) 0: w = 32'hE0900000; 1: w = 32'hE0500000;
                           2: w = 32'hE2900000; default: w = 32'hE2500000; endcase
            w = w + ex + (s << 16) + (d << 12);
        end else if (mj <= 7) begin
            case (h[12:11]) 0: w = 32'hE3B00000; 1: w = 32'hE3500000;
                            2: w = 32'hE2900000; default: w = 32'hE2500000; endcase
            w = w + 32'(h[7:0]) + (r8 << 16) + (r8 << 12);
        end else if (mj == 8 && !h[10]) begin
            logic [31:0] tbl [16];
            tbl = '{32'hE0100000, 32'hE0300000, 32'hE1B00010, 32'hE1B00030,
                    32'hE1B00050, 32'hE0B00000, 32'hE0D00000, 32'hE1B00070,
                    32'hE1100000, 32'hE2700000, 32'hE1500000, 32'hE1700000,
                    32'hE1900000, 32'hE0100090, 32'hE1D00000, 32'hE1F00000};
            w = tbl[op];
            if (op == 2 || op == 3 || op == 4 || op == 7) w = w + (d << 12) + d + (s << 8);
            else if (op == 9)  w = w + (d << 12) + (s << 16);
            else if (op == 13) w = w + (d << 16) + (d << 8) + s;
            else               w = w + (d << 16) + (d << 12) + s;
        end else if (mj == 8) begin
            if (op == 0 || op == 4 || op == 8) st = 2'b01;
            else if (op <= 3)  w = 32'hE0800000 + (hd << 16) + (hd << 12) + hs;
            else if (op <= 7)  w = 32'hE1500000 + (hd << 16) + (hd << 12) + hs;
            else if (op <= 11) w = 32'hE1A00000 + (hd << 16) + (hd << 12) + hs;
            else if (op <= 13) w = 32'hE12FFF10 + 32'(h[6:3]);
            else if (fl)       w = 32'hE1200030 + hs;
            else               st = 2'b01;
        end else if (mj == 9) w = 32'hE59F0000 + (r8 << 12) + (32'(h[7:0]) * 4);
        else if (mj <= 11) begin
            case ({h[9], h[11:10]})
                0: w = 32'hE7800000; 1: w = 32'hE7C00000; 2: w = 32'hE7900000; 3: w = 32'hE7D00000;
                4: w = 32'hE18000B0; 5: w = 32'hE19000D0; 6: w = 32'hE19000B0; default: w = 32'hE19000F0;
            endcase
            w = w + (d << 12) + (s << 16) + ex;
        end else if (mj <= 15) begin
            case (h[12:11]) 0: w = 32'hE5800000; 1: w = 32'hE5900000;
                            2: w = 32'hE5C00000; default: w = 32'hE5D00000; endcase
            w = w + (d << 12) + (s << 16) + 32'(h[10:6]) * (h[12] ? 1 : 4);
        end else if (mj <= 17)
            w = (h[11] ? 32'hE1D000B0 : 32'hE1C000B0) + (d << 12) + (s << 16) + ex * 2 + (32'(h[10:9]) << 8);
        else if (mj <= 19)
            w = (h[11] ? 32'hE59D0000 : 32'hE58D0000) + (r8 << 12) + 32'(h[7:0]) * 4;
        else if (mj <= 21)
            w = (h[11] ? 32'hE28D0F00 : 32'hE28F0F00) + (r8 << 12) + 32'(h[7:0]);
        else if (mj <= 23) begin
            if (h[11:8] == 0) w = (h[7] ? 32'hE24DDF00 : 32'hE28DDF00) + 32'(h[6:0]);
            else if (h[11:8] == 4'hE) st = 2'b01;
            else begin
                case ({h[11], h[8]}) 0: w = 32'hE92D0000; 1: w = 32'hE92D4000;
                                     2: w = 32'hE8BD0000; default: w = 32'hE8BD8000; endcase
                w = w + 32'(h[7:0]);
            end
        end else if (mj <= 25)
            w = (h[11] ? 32'hE8B00000 : 32'hE8A00000) + (r8 << 16) + 32'(h[7:0]);
        else if (mj <= 27) st = (h[11:8] == 4'hE) ? 2'b01 : 2'b10;
        else if (mj == 29) st = h[0] ? 2'b01 : 2'b10;
        else st = 2'b10;
        if (st != 2'b00) w = 32'hDEADC0DE;
    endfunction

    // Requirement tag for a halfword.
    function automatic string tag_for(input logic [15:0] h);
        logic [4:0] mj;
        mj = h[15:11];
        if (mj <= 2) return "R2";
        if (mj == 3) return "R3";
        if (mj <= 7) return "R4";
        if (mj == 8) return !h[10] ? "R5" : (h[9:7] == 3'b111 ? "R7" : "R6");
        if (mj <= 11) return "R8";
        if (mj <= 19) return "R9";
        if (mj <= 21) return "R10";
        if (mj <= 23) return (h[11:8] == 0) ? "R10" : (h[11:8] == 4'hE ? "R12" : "R11");
        if (mj <= 25) return "R11";
        return "R12";
    endfunction

    // Driver: apply one halfword and push its expected result.
    task automatic drive(input logic [15:0] h, input bit be, input bit fl, input string pre);
        item_t it;
        logic [15:0] other;
        other = h ^ 16'hA5C3;
        @(posedge clk);
        fetch_word   <= be ? {h, other} : {other, h};
        big_endian   <= be;
        xchg_call_en <= fl;
        it.h = h;
        ref_expand(h, fl, it.w, it.st);
        it.tag = {pre, tag_for(h), (it.st != 2'b00) ? " R13" : ""};
        sb.push_back(it);
    endtask

    // Monitor: compare outputs away from the rising edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (exp_word !== it.w || exp_status !== it.st) begin
                errors++;
                $display("FAIL %s half=%h got word=%h status=%0d exp word=%h status=%0d",
                         it.tag, it.h, exp_word, exp_status, it.w, it.st);
            end
        end
    end

    // Stimulus: reset state, then full sweeps in both endianness settings.
    initial begin
        drive(16'h0000, 1'b0, 1'b0, "reset ");  // R2 zero halfword during reset
        repeat (3) @(posedge clk);
        rst_n <= 1'b1;
        for (int i = 0; i < 65536; i++) drive(16'(i), 1'b0, 1'b1, "");
        for (int i = 0; i < 65536; i++) drive(16'(i), 1'b1, 1'b0, "R1 ");
        repeat (3) @(posedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R13 scoreboard left %0d expected 0", sb.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired, got running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule